// File: doc/BRIEF.md
# Coprocessor byte DMA engine

This block copies bytes between the three memories a cartridge coprocessor can reach: a mask ROM, a battery-backed work RAM (called BWRAM here) and a small internal RAM (IRAM). A host programs it through a byte-wide register window. It writes a control byte, a 24-bit source address, a 16-bit byte count and a 24-bit destination address. Writing one particular destination byte starts the copy. Which byte that is depends on the destination device.

Once started, the engine spends two cycles on each byte. In the first cycle it issues a read request, and the memory answers with a fixed one-cycle latency. In the second cycle it issues a write request that carries the captured byte. Source and destination addresses advance by one after every byte, and the count falls by one. Bus addresses are translated into device addresses as they go out. When the last byte is done, a sticky coprocessor-side interrupt flag rises. A conversion-mode setting does not start a copy. Instead, it raises a separate host-side conversion interrupt flag.

Top module: `dma_byte_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `rd_req`, `wr_req`, `dma_irq` and `cc_irq` are all low.
- R2: Register offsets are 0x30 control, 0x32/0x33/0x34 source low/mid/high, 0x35/0x36/0x37 destination low/mid/high, and 0x38/0x39 count low/high. Control bit 7 enables the engine. Bit 5 set selects conversion mode and clear selects copy mode. Bit 4 selects conversion type 1. Bit 2 selects the destination (0 IRAM, 1 BWRAM). Bits 1:0 select the source (0 ROM, 1 BWRAM, 2 IRAM, 3 none).
- R3: In enabled copy mode with an IRAM destination, writing offset 0x36 starts a transfer. Writing offset 0x37 does not.
- R4: In enabled copy mode with a BWRAM destination, writing offset 0x37 starts a transfer. Writing offset 0x36 does not.
- R5: With control bit 7 clear, no destination write starts anything.
- R6: Byte k is handled in two cycles. Its read cycle is cycle 2k+1 after the triggering edge, with `rd_req` high. Its write cycle is cycle 2k+2, with `wr_req` high and `wr_data` equal to the value returned on `rd_data` in that cycle. `rd_sel` uses 0 ROM, 1 BWRAM and 2 IRAM. `wr_sel` uses 0 IRAM and 1 BWRAM. Both addresses advance by one for each byte.
- R7: For BWRAM-to-BWRAM or IRAM-to-IRAM pairs, a byte makes neither a read nor a write, but it still takes its two cycles and advances the addresses.
- R8: A ROM source address is valid in banks 00–3F or 80–BF with A15 = 1, and in banks C0–FF. A valid address goes out as `rd_addr` = A[22:0]. An invalid one makes no read, and the byte is written as 0.
- R9: A BWRAM address in 6000–7FFF of banks 00–3F or 80–BF maps to `bw_bank`×0x2000 + A[12:0]. In banks 40–4F it maps to A[19:0]. Any other BWRAM address makes no access, and an unmapped source reads as 0.
- R10: An IRAM address uses only A[10:0].
- R11: On the edge after the last write cycle, `busy` falls and `dma_irq` rises and stays high. A start with a count of 0 moves no bytes and raises `dma_irq` one edge later.
- R12: In enabled conversion mode with type 1 selected, writing offset 0x36 sets `cc_irq` and moves no bytes. With type 1 not selected it does nothing.
- R13: A register write made while `busy` is high is stored but does not restart or lengthen the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset within the block window |
| reg_wdata | input | 8 | Register write data |
| bw_bank | input | BANK_W | BWRAM window bank select |
| busy | output | 1 | Transfer in progress |
| rd_req | output | 1 | Read request |
| rd_sel | output | 2 | Read device: 0 ROM, 1 BWRAM, 2 IRAM |
| rd_addr | output | 24 | Translated read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_req` |
| wr_req | output | 1 | Write request |
| wr_sel | output | 1 | Write device: 0 IRAM, 1 BWRAM |
| wr_addr | output | BW_AW | Translated write address |
| wr_data | output | 8 | Write data |
| dma_irq | output | 1 | Sticky transfer-complete flag |
| cc_irq | output | 1 | Sticky conversion type 1 flag |

## Verification
Each of the engine's internal registers has a visible signature at the ports. A wrong state register or phase shows up within one cycle as a request that appears in the wrong cycle of the two-cycle byte rhythm. A wrong count shows up at the end of the transfer, as `busy` and `dma_irq` changing on the wrong edge. A wrong address register or a wrong translation shows up on the very next request as a mismatched `rd_addr`, `wr_addr` or device select. This is also true of a missing or spurious suppression for a same-device pair, or of an unmapped window. The bench therefore sweeps every source and destination device, crosses each address-window boundary, and checks every cycle of every byte.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} xfer_state_e;

  localparam logic [1:0] SRC_ROM  = 2'd0;
  localparam logic [1:0] SRC_BW   = 2'd1;
  localparam logic [1:0] SRC_IRAM = 2'd2;

  // ROM visible in upper half of banks 00-3F/80-BF, or anywhere in C0-FF
  function automatic logic rom_hit(input logic [23:0] a);
    return (!a[22] && a[15]) || (a[23:22] == 2'b11);
  endfunction

  // 8 KB work-RAM window at 6000-7FFF of banks 00-3F/80-BF
  function automatic logic bw_window(input logic [23:0] a);
    return !a[22] && (a[15:13] == 3'b011);
  endfunction

  // linear work-RAM image in banks 40-4F
  function automatic logic bw_linear(input logic [23:0] a);
    return a[23:20] == 4'h4;
  endfunction

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int REG_AW = 9,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              adv,
  output logic [7:0]        ctrl,
  output logic [23:0]       src,
  output logic [23:0]       dst,
  output logic [CNT_W-1:0]  cnt,
  output logic              hit_dmid,
  output logic              hit_dhigh
);
  localparam logic [REG_AW-1:0] OFS_CTRL  = REG_AW'('h30);
  localparam logic [REG_AW-1:0] OFS_SRC_L = REG_AW'('h32);
  localparam logic [REG_AW-1:0] OFS_SRC_M = REG_AW'('h33);
  localparam logic [REG_AW-1:0] OFS_SRC_H = REG_AW'('h34);
  localparam logic [REG_AW-1:0] OFS_DST_L = REG_AW'('h35);
  localparam logic [REG_AW-1:0] OFS_DST_M = REG_AW'('h36);
  localparam logic [REG_AW-1:0] OFS_DST_H = REG_AW'('h37);
  localparam logic [REG_AW-1:0] OFS_CNT_L = REG_AW'('h38);
  localparam logic [REG_AW-1:0] OFS_CNT_H = REG_AW'('h39);

  assign hit_dmid  = we && (addr == OFS_DST_M);
  assign hit_dhigh = we && (addr == OFS_DST_H);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
    end else begin
      if (adv) begin
        src <= src + 24'd1;
        dst <= dst + 24'd1;
        cnt <= cnt - CNT_W'(1);
      end
      if (we) begin
        case (addr)
          OFS_CTRL:  ctrl <= wdata;
          OFS_SRC_L: src[7:0]   <= wdata;
          OFS_SRC_M: src[15:8]  <= wdata;
          OFS_SRC_H: src[23:16] <= wdata;
          OFS_DST_L: dst[7:0]   <= wdata;
          OFS_DST_M: dst[15:8]  <= wdata;
          OFS_DST_H: dst[23:16] <= wdata;
          OFS_CNT_L: cnt[7:0]   <= wdata;
          OFS_CNT_H: cnt[CNT_W-1:8] <= (CNT_W-8)'(wdata);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map
  import dma_pkg::*;
#(
  parameter int BANK_W  = 7,
  parameter int IRAM_AW = 11,
  localparam int BW_AW  = BANK_W + 13
) (
  input  logic [1:0]        src_dev,
  input  logic              dst_is_bw,
  input  logic [23:0]       src,
  input  logic [23:0]       dst,
  input  logic [BANK_W-1:0] bank,
  output logic              src_ok,
  output logic              dst_ok,
  output logic              same_dev,
  output logic [1:0]        rd_sel,
  output logic [23:0]       rd_addr,
  output logic              wr_sel,
  output logic [BW_AW-1:0]  wr_addr
);
  assign same_dev = ((src_dev == SRC_BW) && dst_is_bw) ||
                    ((src_dev == SRC_IRAM) && !dst_is_bw);
  assign rd_sel = src_dev;
  assign wr_sel = dst_is_bw;

  always_comb begin
    src_ok  = 1'b0;
    rd_addr = '0;
    case (src_dev)
      SRC_ROM: begin
        src_ok  = rom_hit(src);
        rd_addr = {1'b0, src[22:0]};
      end
      SRC_BW: begin
        if (bw_window(src)) begin
          src_ok  = 1'b1;
          rd_addr = 24'({bank, src[12:0]});
        end else if (bw_linear(src)) begin
          src_ok  = 1'b1;
          rd_addr = 24'(src[19:0]);
        end
      end
      SRC_IRAM: begin
        src_ok  = 1'b1;
        rd_addr = 24'(src[IRAM_AW-1:0]);
      end
      default: ;
    endcase
  end

  always_comb begin
    dst_ok  = 1'b0;
    wr_addr = '0;
    if (!dst_is_bw) begin
      dst_ok  = 1'b1;
      wr_addr = BW_AW'(dst[IRAM_AW-1:0]);
    end else if (bw_window(dst)) begin
      dst_ok  = 1'b1;
      wr_addr = {bank, dst[12:0]};
    end else if (bw_linear(dst)) begin
      dst_ok  = 1'b1;
      wr_addr = BW_AW'(dst[19:0]);
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             conv,
  input  logic             conv_t1,
  input  logic             dst_is_bw,
  input  logic             hit_dmid,
  input  logic             hit_dhigh,
  input  logic [CNT_W-1:0] cnt,
  input  logic             src_ok,
  input  logic             dst_ok,
  input  logic             same_dev,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             adv,
  output logic             rd_req,
  output logic             wr_req,
  output logic [7:0]       wr_data,
  output logic             dma_irq,
  output logic             cc_irq
);
  xfer_state_e state;
  logic        rd_took;
  logic        start;

  assign start   = en && !conv && (state == ST_IDLE) && (dst_is_bw ? hit_dhigh : hit_dmid);
  assign busy    = (state != ST_IDLE);
  assign adv     = (state == ST_WR);
  assign rd_req  = (state == ST_RD) && src_ok && !same_dev;
  assign wr_req  = (state == ST_WR) && dst_ok && !same_dev;
  assign wr_data = rd_took ? rd_data : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rd_took <= 1'b0;
      dma_irq <= 1'b0;
      cc_irq  <= 1'b0;
    end else begin
      if (en && conv && conv_t1 && hit_dmid) cc_irq <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          if (cnt == '0) dma_irq <= 1'b1;
          else           state   <= ST_RD;
        end
        ST_RD: begin
          rd_took <= rd_req;
          state   <= ST_WR;
        end
        ST_WR: begin
          if (cnt == CNT_W'(1)) begin
            state   <= ST_IDLE;
            dma_irq <= 1'b1;
          end else begin
            state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a write cycle always comes right after a read cycle
  a_r6_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> $past(state == ST_RD));
  // R6: requests only while busy, never both at once
  a_r6_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req) |-> (busy && !(rd_req && wr_req)));
  // R7: same-device pairs touch no memory
  a_r7_same_dev_quiet: assert property (@(posedge clk) disable iff (rst)
    same_dev |-> (!rd_req && !wr_req));
  // R11: end of transfer raises the completion flag
  a_r11_fall_sets_irq: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> dma_irq);
  // R11: completion flag is sticky
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    dma_irq |=> dma_irq);
  // R5: disabled engine stays idle
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !en) |=> (state == ST_IDLE));
endmodule

// File: rtl/dma_byte_engine.sv
module dma_byte_engine #(
  parameter int REG_AW  = 9,
  parameter int CNT_W   = 16,
  parameter int BANK_W  = 7,
  parameter int IRAM_AW = 11,
  localparam int BW_AW  = BANK_W + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [BANK_W-1:0] bw_bank,
  output logic              busy,
  output logic              rd_req,
  output logic [1:0]        rd_sel,
  output logic [23:0]       rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_req,
  output logic              wr_sel,
  output logic [BW_AW-1:0]  wr_addr,
  output logic [7:0]        wr_data,
  output logic              dma_irq,
  output logic              cc_irq
);
  logic [7:0]       ctrl;
  logic [23:0]      src, dst;
  logic [CNT_W-1:0] cnt;
  logic             hit_dmid, hit_dhigh, adv;
  logic             src_ok, dst_ok, same_dev;
  logic             unused_ctrl;

  assign unused_ctrl = ctrl[6] ^ ctrl[3];

  dma_regfile #(.REG_AW(REG_AW), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .adv(adv), .ctrl(ctrl), .src(src), .dst(dst), .cnt(cnt),
    .hit_dmid(hit_dmid), .hit_dhigh(hit_dhigh)
  );

  dma_addr_map #(.BANK_W(BANK_W), .IRAM_AW(IRAM_AW)) map_i (
    .src_dev(ctrl[1:0]), .dst_is_bw(ctrl[2]), .src(src), .dst(dst),
    .bank(bw_bank), .src_ok(src_ok), .dst_ok(dst_ok), .same_dev(same_dev),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .wr_sel(wr_sel), .wr_addr(wr_addr)
  );

  dma_xfer_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst(rst), .en(ctrl[7]), .conv(ctrl[5]), .conv_t1(ctrl[4]),
    .dst_is_bw(ctrl[2]), .hit_dmid(hit_dmid), .hit_dhigh(hit_dhigh),
    .cnt(cnt), .src_ok(src_ok), .dst_ok(dst_ok), .same_dev(same_dev),
    .rd_data(rd_data), .busy(busy), .adv(adv), .rd_req(rd_req),
    .wr_req(wr_req), .wr_data(wr_data), .dma_irq(dma_irq), .cc_irq(cc_irq)
  );

  // R13: a register write during a transfer never restarts it
  a_r13_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !adv) |=> busy);
endmodule

// File: tb/dma_byte_engine_tb.sv
module dma_byte_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [6:0]  bw_bank = '0;
  logic        busy, rd_req, wr_req, wr_sel, dma_irq, cc_irq;
  logic [1:0]  rd_sel;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic [19:0] wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_hold = '0;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  dma_byte_engine dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bw_bank(bw_bank), .busy(busy), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data), .wr_req(wr_req),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .dma_irq(dma_irq), .cc_irq(cc_irq)
  );

  function automatic logic [7:0] mdl(input logic [1:0] sel, input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {sel, 6'h15};
  endfunction

  // memory model: one-cycle read latency
  always @(negedge clk) rd_hold <= mdl(rd_sel, rd_addr);
  always @(posedge clk) rd_data <= rd_hold;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [8:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input string tag, input logic [7:0] ctrl, input logic [23:0] s0,
                     input logic [23:0] d0, input int cnt, input logic [6:0] bank,
                     input bit inj);
    logic [1:0] sdev;
    logic       dbw, supp, sok, dok;
    logic [23:0] s, d, ea;
    logic [19:0] wa;
    logic [7:0]  ed;
    do_reset();
    bw_bank = bank;
    sdev = ctrl[1:0];
    dbw  = ctrl[2];
    wreg(9'h30, ctrl);
    wreg(9'h32, s0[7:0]); wreg(9'h33, s0[15:8]); wreg(9'h34, s0[23:16]);
    wreg(9'h38, 8'(cnt)); wreg(9'h39, 8'(cnt >> 8));
    wreg(9'h35, d0[7:0]);
    if (dbw) begin
      wreg(9'h36, d0[15:8]);
      chk("R4 mid write no start", busy, 0);
      wreg(9'h37, d0[23:16]);
    end else begin
      wreg(9'h37, d0[23:16]);
      chk("R3 high write no start", busy, 0);
      wreg(9'h36, d0[15:8]);
    end
    for (int k = 0; k < cnt; k++) begin
      s = s0 + 24'(k);
      d = d0 + 24'(k);
      supp = (sdev == 2'd1 && dbw) || (sdev == 2'd2 && !dbw);
      sok = 1'b0; ea = '0;
      if (sdev == 2'd0) begin
        sok = (!s[22] && s[15]) || (s[23:22] == 2'b11);
        ea = {1'b0, s[22:0]};
      end else if (sdev == 2'd1) begin
        if (!s[22] && s[15:13] == 3'b011) begin sok = 1; ea = 24'(bank) * 24'h2000 + 24'(s[12:0]); end
        else if (s[23:20] == 4'h4) begin sok = 1; ea = 24'(s[19:0]); end
      end else if (sdev == 2'd2) begin
        sok = 1; ea = 24'(s[10:0]);
      end
      dok = 1'b0; wa = '0;
      if (!dbw) begin dok = 1; wa = 20'(d[10:0]); end
      else if (!d[22] && d[15:13] == 3'b011) begin dok = 1; wa = 20'(bank) * 20'h2000 + 20'(d[12:0]); end
      else if (d[23:20] == 4'h4) begin dok = 1; wa = d[19:0]; end
      // read cycle
      if (k == 0) begin
        chk({tag, " R6 busy at first byte"}, busy, 1);
        chk({tag, " R11 irq low during"}, dma_irq, 0);
      end
      chk({tag, " rd_req"}, rd_req, sok && !supp);
      chk({tag, " R6 no write in read cycle"}, wr_req, 0);
      if (sok && !supp) begin
        chk({tag, " R6 rd_sel"}, rd_sel, sdev);
        chk({tag, " rd_addr"}, rd_addr, ea);
      end
      if (inj && k == 0) begin
        reg_we = 1'b1; reg_addr = 9'h36; reg_wdata = d0[15:8];
      end
      @(negedge clk);
      reg_we = 1'b0;
      // write cycle
      ed = (sok && !supp) ? mdl(sdev, ea) : 8'h00;
      chk({tag, " wr_req"}, wr_req, dok && !supp);
      chk({tag, " R6 no read in write cycle"}, rd_req, 0);
      if (dok && !supp) begin
        chk({tag, " R6 wr_sel"}, wr_sel, dbw);
        chk({tag, " wr_addr"}, wr_addr, wa);
        chk({tag, " wr_data"}, wr_data, ed);
      end
      @(negedge clk);
    end
    chk({tag, " R11 busy falls"}, busy, 0);
    chk({tag, " R11 dma_irq set"}, dma_irq, 1);
    chk({tag, " R12 cc_irq untouched"}, cc_irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", busy, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 dma_irq", dma_irq, 0);
    chk("R1 cc_irq", cc_irq, 0);

    run("R6 rom->iram",       8'h80, 24'h008000, 24'h003000, 4, 7'd0,  0);
    run("R8 rom edge",        8'h80, 24'h007FFE, 24'h0037FE, 4, 7'd0,  0);
    run("R2 rom hi->bw lin",  8'h84, 24'hC01234, 24'h400010, 3, 7'd0,  0);
    run("R8 rom bank cross",  8'h84, 24'h3FFFFF, 24'h006000, 3, 7'd3,  0);
    run("R9 bw win->iram",    8'h81, 24'h007FFE, 24'h000100, 4, 7'd3,  0);
    run("R9 bw lin->iram",    8'h81, 24'h4FFFFE, 24'h0007FF, 4, 7'd1,  0);
    run("R10 iram->bw win",   8'h86, 24'h0007FE, 24'h817FFE, 4, 7'h7F, 0);
    run("R7 bw->bw",          8'h85, 24'h406000, 24'h400000, 3, 7'd2,  0);
    run("R7 iram->iram",      8'h82, 24'h000010, 24'h000020, 3, 7'd0,  0);
    run("R9 dst unmapped",    8'h84, 24'h808000, 24'h005FFE, 4, 7'd4,  0);
    run("R13 write while busy", 8'h80, 24'h809000, 24'h001200, 3, 7'd0, 1);

    // R11: zero count
    do_reset();
    wreg(9'h30, 8'h80);
    wreg(9'h36, 8'h12);
    chk("R11 zero count busy", busy, 0);
    chk("R11 zero count irq", dma_irq, 1);
    chk("R11 zero count rd_req", rd_req, 0);

    // R5: enable clear
    do_reset();
    wreg(9'h30, 8'h00);
    wreg(9'h38, 8'h02);
    wreg(9'h36, 8'h12);
    chk("R5 no busy", busy, 0);
    chk("R5 no read", rd_req, 0);
    @(negedge clk);
    chk("R5 no irq", dma_irq, 0);

    // R12: conversion type 1 and other conversion types
    do_reset();
    wreg(9'h38, 8'h02);
    wreg(9'h30, 8'hA0);
    wreg(9'h36, 8'h12);
    chk("R12 other type cc_irq", cc_irq, 0);
    chk("R12 other type busy", busy, 0);
    wreg(9'h30, 8'hB0);
    wreg(9'h36, 8'h12);
    chk("R12 type1 cc_irq", cc_irq, 1);
    chk("R12 type1 no copy", busy, 0);
    @(negedge clk);
    chk("R12 type1 no dma_irq", dma_irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule